// File: doc/BRIEF.md
# Serial Register Host Port

This block is the slave side of a serial host port. An external controller uses it to read and write a bank of 8-bit registers held inside the block. The controller drives a serial clock, an active-low chip select and serial data in. A static select input chooses which serial clock edge launches read data. The block drives serial data out together with an output enable, so that a pad or a wired bus can place the line in high impedance.

A transfer is two bytes long, sent most significant bit first. The first byte is the command: its top bit is the direction flag and its low five bits are the register address. The second byte is write data that the host sends, or read data that the block returns. All port inputs are brought into the system clock domain through synchronizer stages, and serial clock edges are detected there. The register bank, the sequencer and the output launch logic all run on the system clock.

When chip select is released in the middle of a transfer, the transfer is abandoned without side effects. Serial clocks that arrive after the second byte are ignored until chip select is released.

Top module: `sreg_host_port`

## Requirements
- R1: SDI is sampled on rising SCLK edges, most significant bit first. In the command byte, bit 7 is the direction flag (1 = read, 0 = write), bits 4:0 are the register address, and bits 6:5 have no effect.
- R2: After a write transfer of eight complete data bits, a later read of the same address returns the written byte.
- R3: `sdo_oe` stays low for the whole of a write transfer.
- R4: In a read transfer, `sdo_oe` stays low until the eighth rising SCLK edge (the end of the command byte).
- R5: When `edge_sel` is high, read data changes only after falling SCLK edges. Bit 7 is valid after the falling edge that follows the eighth rising edge, and each later falling edge presents the next lower bit, up to bit 0.
- R6: When `edge_sel` is low, read data changes only after rising SCLK edges. Bit 7 is valid from the eighth rising edge, and each rising edge from the ninth to the fifteenth presents the next lower bit.
- R7: Raising `cs_n` abandons the transfer: `sdo_oe` goes low, and the next transfer starts again with a command byte.
- R8: A write whose data byte is cut short by raising `cs_n` leaves the register unchanged.
- R9: Rising SCLK edges after the sixteenth bit are ignored until `cs_n` rises, and they do not change the register that was written.
- R10: After reset, every register reads as 0x00 and `sdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low chip select that frames one transfer |
| sdi | input | 1 | Serial data from the host |
| edge_sel | input | 1 | Launch edge select for read data: 1 = falling, 0 = rising |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Output enable for `sdo`; low means high impedance |

## Verification
The hardest cases to reach from the ports are transfers cut off at chosen bit positions, because the bank must then be shown to be untouched and the next command must still be decoded correctly. The bench can stop a transfer after any number of bits, including counts past sixteen. It cuts transfers inside the command byte, inside a write data byte and inside a read data byte, then reads the affected address back with a complete transfer. Randomly ordered reads and writes with random ignored command bits and random launch-edge settings cover both edge modes against a reference register model.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

   // lane positions inside the input synchronizer bundle
   localparam int unsigned LANE_SCLK  = 0;
   localparam int unsigned LANE_CSN   = 1;
   localparam int unsigned LANE_SDI   = 2;
   localparam int unsigned LANE_ESEL  = 3;
   localparam int unsigned LANE_COUNT = 4;

   // idle level of each lane, applied while in reset (chip select idles high)
   localparam logic [LANE_COUNT-1:0] LANE_IDLE = 4'b0010;

   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_DATA = 2'd1,
      PH_DONE = 2'd2
   } phase_e;

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
   parameter int unsigned             LANES   = 4,
   parameter int unsigned             STAGES  = 2,
   parameter logic [LANES-1:0]        IDLE    = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] async_i,
   output logic [LANES-1:0] sync_o
);

   initial begin
      assert (STAGES >= 2) else $error("sreg_sync: STAGES must be at least 2");
      assert (LANES >= 1)  else $error("sreg_sync: LANES must be at least 1");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [STAGES-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q <= {STAGES{IDLE[g]}};
         else        pipe_q <= {pipe_q[STAGES-2:0], async_i[g]};
      end
      assign sync_o[g] = pipe_q[STAGES-1];
   end

endmodule

// File: rtl/sreg_edge.sv
module sreg_edge #(
   parameter logic IDLE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic rise_o,
   output logic fall_o
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE;
      else        prev_q <= level_i;
   end

   assign rise_o =  level_i & ~prev_q;
   assign fall_o = ~level_i &  prev_q;

endmodule

// File: rtl/sreg_bank.sv
module sreg_bank #(
   parameter int unsigned        ADDR_W  = 5,
   parameter int unsigned        REG_W   = 8,
   parameter logic [REG_W-1:0]   RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [REG_W-1:0]  wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [REG_W-1:0]  rd_data_o
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 8) else $error("sreg_bank: ADDR_W out of range");
   end

   logic [REG_W-1:0] mem_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                     mem_q[e] <= RST_VAL;
         else if (we_i && wr_addr_i == ADDR_W'(e))       mem_q[e] <= wr_data_i;
      end
   end

   assign rd_data_o = mem_q[rd_addr_i];

   // R2: a commit is visible at the written address on the next cycle
   p_write_lands_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i));

endmodule

// File: rtl/sreg_seq.sv
module sreg_seq
   import sreg_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned REG_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act_i,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              sdi_i,
   input  logic              edge_sel_i,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [REG_W-1:0]  rd_data_i,
   output logic              we_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [REG_W-1:0]  wr_data_o,
   output logic              sdo_o,
   output logic              sdo_oe_o
);

   localparam int unsigned CNT_W = $clog2(REG_W);
   localparam int unsigned REM_W = $clog2(REG_W + 1);

   initial begin
      assert (REG_W >= 4 && (REG_W & (REG_W - 1)) == 0)
         else $error("sreg_seq: REG_W must be a power of two of at least 4");
      assert (ADDR_W < REG_W) else $error("sreg_seq: address must leave room for the flag bit");
   end

   phase_e             phase_q;
   logic [CNT_W-1:0]   bit_q;
   logic [REG_W-2:0]   sh_q;
   logic [REG_W-1:0]   rd_buf_q;
   logic [REM_W-1:0]   rem_q;
   logic [ADDR_W-1:0]  addr_q;
   logic               rd_mode_q;
   logic               oe_q;
   logic               sdo_q;

   logic [REG_W-1:0]   frame_w;
   logic               last_bit;
   logic               cmd_end;
   logic               data_end;
   logic               launch_evt;
   logic               launch_go;

   assign frame_w    = {sh_q, sdi_i};
   assign last_bit   = (bit_q == CNT_W'(REG_W - 1));
   assign cmd_end    = cs_act_i && rise_i && phase_q == PH_CMD  && last_bit;
   assign data_end   = cs_act_i && rise_i && phase_q == PH_DATA && last_bit;
   assign launch_evt = edge_sel_i ? fall_i : rise_i;
   assign launch_go  = cs_act_i && launch_evt && rem_q != '0 && !cmd_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_CMD;
         bit_q     <= '0;
         sh_q      <= '0;
         rd_buf_q  <= '0;
         rem_q     <= '0;
         addr_q    <= '0;
         rd_mode_q <= 1'b0;
         oe_q      <= 1'b0;
         sdo_q     <= 1'b0;
      end else if (!cs_act_i) begin
         phase_q   <= PH_CMD;
         bit_q     <= '0;
         rem_q     <= '0;
         rd_mode_q <= 1'b0;
         oe_q      <= 1'b0;
         sdo_q     <= 1'b0;
      end else begin
         if (rise_i && phase_q != PH_DONE) begin
            sh_q  <= frame_w[REG_W-2:0];
            bit_q <= last_bit ? '0 : bit_q + 1'b1;
         end
         if (cmd_end) begin
            phase_q   <= PH_DATA;
            rd_mode_q <= frame_w[REG_W-1];
            addr_q    <= frame_w[ADDR_W-1:0];
            if (frame_w[REG_W-1]) begin
               if (edge_sel_i) begin
                  rd_buf_q <= rd_data_i;
                  rem_q    <= REM_W'(REG_W);
               end else begin
                  sdo_q    <= rd_data_i[REG_W-1];
                  rd_buf_q <= {rd_data_i[REG_W-2:0], 1'b0};
                  rem_q    <= REM_W'(REG_W - 1);
                  oe_q     <= 1'b1;
               end
            end
         end else if (data_end) begin
            phase_q <= PH_DONE;
         end
         if (launch_go) begin
            sdo_q    <= rd_buf_q[REG_W-1];
            rd_buf_q <= {rd_buf_q[REG_W-2:0], 1'b0};
            rem_q    <= rem_q - 1'b1;
            oe_q     <= 1'b1;
         end
      end
   end

   assign rd_addr_o = frame_w[ADDR_W-1:0];
   assign we_o      = data_end && !rd_mode_q;
   assign wr_addr_o = addr_q;
   assign wr_data_o = frame_w;
   assign sdo_o     = sdo_q;
   assign sdo_oe_o  = oe_q;

   // R1: the command bit position advances only on a serial rising edge
   p_count_on_rise_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CMD && $past(phase_q == PH_CMD) && $past(cs_act_i) && !$stable(bit_q))
         |-> $past(rise_i));

   // R3: no drive once a write command has been decoded
   p_write_quiet_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_CMD && !rd_mode_q) |-> !oe_q);

   // R4: no drive while the command byte is still arriving
   p_cmd_quiet_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CMD) |-> !oe_q);

   // R5: falling-edge mode moves the data line only after a falling edge
   p_fall_launch_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q && edge_sel_i && $past(edge_sel_i) && cs_act_i && $past(cs_act_i) && !$stable(sdo_q))
         |-> $past(fall_i));

   // R6: rising-edge mode moves the data line only after a rising edge
   p_rise_launch_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q && !edge_sel_i && $past(!edge_sel_i) && cs_act_i && $past(cs_act_i) && !$stable(sdo_q))
         |-> $past(rise_i));

   // R7: releasing chip select stops driving and rewinds to the command byte
   p_abort_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act_i |=> (!oe_q && phase_q == PH_CMD && bit_q == '0));

   // R8: a commit closes the data phase, so it occurs at most once per transfer
   p_commit_once_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      we_o |=> (phase_q == PH_DONE && !we_o));

   // R9: edges after the data byte leave the sequencer parked
   p_done_parked_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DONE && cs_act_i) |=> (phase_q == PH_DONE || !$past(cs_act_i) || !cs_act_i));

endmodule

// File: rtl/sreg_host_port.sv
module sreg_host_port
   import sreg_pkg::*;
#(
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned REG_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic sdi,
   input  logic edge_sel,
   output logic sdo,
   output logic sdo_oe
);

   initial begin
      assert (SYNC_STAGES >= 2) else $error("sreg_host_port: SYNC_STAGES below 2");
      assert (ADDR_W < REG_W)   else $error("sreg_host_port: ADDR_W too wide for command byte");
   end

   logic [LANE_COUNT-1:0] raw_w;
   logic [LANE_COUNT-1:0] syn_w;
   logic                  sclk_rise;
   logic                  sclk_fall;
   logic [ADDR_W-1:0]     rd_addr;
   logic [REG_W-1:0]      rd_data;
   logic                  wr_en;
   logic [ADDR_W-1:0]     wr_addr;
   logic [REG_W-1:0]      wr_data;

   assign raw_w[LANE_SCLK] = sclk;
   assign raw_w[LANE_CSN]  = cs_n;
   assign raw_w[LANE_SDI]  = sdi;
   assign raw_w[LANE_ESEL] = edge_sel;

   sreg_sync #(
      .LANES  (LANE_COUNT),
      .STAGES (SYNC_STAGES),
      .IDLE   (LANE_IDLE)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (raw_w),
      .sync_o  (syn_w)
   );

   sreg_edge #(
      .IDLE (LANE_IDLE[LANE_SCLK])
   ) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (syn_w[LANE_SCLK]),
      .rise_o  (sclk_rise),
      .fall_o  (sclk_fall)
   );

   sreg_seq #(
      .ADDR_W (ADDR_W),
      .REG_W  (REG_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_act_i   (~syn_w[LANE_CSN]),
      .rise_i     (sclk_rise),
      .fall_i     (sclk_fall),
      .sdi_i      (syn_w[LANE_SDI]),
      .edge_sel_i (syn_w[LANE_ESEL]),
      .rd_addr_o  (rd_addr),
      .rd_data_i  (rd_data),
      .we_o       (wr_en),
      .wr_addr_o  (wr_addr),
      .wr_data_o  (wr_data),
      .sdo_o      (sdo),
      .sdo_oe_o   (sdo_oe)
   );

   sreg_bank #(
      .ADDR_W  (ADDR_W),
      .REG_W   (REG_W),
      .RST_VAL ('0)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_i      (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data)
   );

   // R7: while deselected the output is never enabled
   p_deselect_hiz_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (syn_w[LANE_CSN] && $past(syn_w[LANE_CSN])) |-> !sdo_oe);

endmodule

// File: tb/sreg_host_port_bench.sv
module sreg_host_port_bench;

   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic cs_n = 1'b1;
   logic sdi = 1'b0;
   logic edge_sel = 1'b0;
   logic sdo;
   logic sdo_oe;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   logic [7:0] model [32];

   always #10 clk = ~clk;

   sreg_host_port u_sreg_host_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk     (sclk),
      .cs_n     (cs_n),
      .sdi      (sdi),
      .edge_sel (edge_sel),
      .sdo      (sdo),
      .sdo_oe   (sdo_oe)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                        input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] cmd_byte(input logic rd, input logic [4:0] a,
                                           input logic [1:0] junk);
      return {rd, junk, a};
   endfunction

   // one framed transfer of nbits serial clocks; returns the byte seen on sdo
   // and the number of sample points where the enable had the wrong level
   task automatic xfer(input logic [7:0] cmd, input logic [7:0] wdat, input int nbits,
                       input logic sel, output logic [7:0] rdat, output int oe_bad);
      rdat = '0;
      oe_bad = 0;
      edge_sel = sel;
      tick(4);
      cs_n = 1'b0;
      tick(HALF);
      for (int i = 0; i < nbits; i++) begin
         if (i < 8)       sdi = cmd[7-i];
         else if (i < 16) sdi = wdat[15-i];
         else             sdi = ~wdat[(i-16) % 8];
         tick(HALF);
         if (i < 8 && sdo_oe !== 1'b0) oe_bad++;
         if (!cmd[7] && sdo_oe !== 1'b0) oe_bad++;
         if (cmd[7] && sel && i >= 8 && i < 16) begin
            rdat[15-i] = sdo;
            if (sdo_oe !== 1'b1) oe_bad++;
         end
         sclk = 1'b1;
         tick(HALF);
         if (i < 7 && sdo_oe !== 1'b0) oe_bad++;
         if (!cmd[7] && sdo_oe !== 1'b0) oe_bad++;
         if (cmd[7] && !sel && i >= 7 && i < 15) begin
            rdat[14-i] = sdo;
            if (sdo_oe !== 1'b1) oe_bad++;
         end
         sclk = 1'b0;
      end
      tick(HALF);
      cs_n = 1'b1;
      tick(6);
   endtask

   task automatic do_write(input logic [4:0] a, input logic [7:0] d, input logic sel,
                           input logic [1:0] junk, input string req);
      logic [7:0] rd;
      int bad;
      xfer(cmd_byte(1'b0, a, junk), d, 16, sel, rd, bad);
      check(req, bad, 0, "enable raised during write");
      model[a] = d;
   endtask

   task automatic do_read(input logic [4:0] a, input logic sel, input logic [1:0] junk,
                          input string req);
      logic [7:0] rd;
      int bad;
      xfer(cmd_byte(1'b1, a, junk), 8'h00, 16, sel, rd, bad);
      check(req, bad, 0, "enable level during read");
      check(req, rd, model[a], $sformatf("read data addr %0d sel %0b", a, sel));
   endtask

   initial begin
      tick(150000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] rd;
      int bad;
      void'($urandom(32'd2024));
      for (int k = 0; k < 32; k++) model[k] = 8'h00;

      // R10: reset state
      rst_n = 1'b0;
      tick(5);
      check("R10", sdo_oe, 1'b0, "enable in reset");
      rst_n = 1'b1;
      tick(4);
      check("R10", sdo_oe, 1'b0, "enable after reset");
      do_read(5'd3, 1'b1, 2'b00, "R10");
      do_read(5'd31, 1'b0, 2'b00, "R10");

      // R2 R3 R5 R6: write then read back in both launch modes
      do_write(5'd5, 8'hA5, 1'b0, 2'b00, "R3");
      do_read(5'd5, 1'b1, 2'b00, "R5");
      do_read(5'd5, 1'b0, 2'b00, "R6");
      do_write(5'd0, 8'hFF, 1'b1, 2'b00, "R2");
      do_write(5'd31, 8'h01, 1'b0, 2'b00, "R2");
      do_read(5'd0, 1'b0, 2'b00, "R2");
      do_read(5'd31, 1'b1, 2'b00, "R2");

      // R1: bits 6:5 of the command have no effect
      do_write(5'd9, 8'h3C, 1'b1, 2'b11, "R1");
      do_read(5'd9, 1'b0, 2'b00, "R1");
      do_read(5'd9, 1'b1, 2'b10, "R1");

      // R8: write cut short after five data bits
      xfer(cmd_byte(1'b0, 5'd5, 2'b00), 8'h5A, 13, 1'b0, rd, bad);
      check("R8", bad, 0, "enable during partial write");
      do_read(5'd5, 1'b1, 2'b00, "R8");
      // R8: write cut short one bit before the end
      xfer(cmd_byte(1'b0, 5'd5, 2'b00), 8'h00, 15, 1'b1, rd, bad);
      do_read(5'd5, 1'b0, 2'b00, "R8");

      // R7: abort inside a read command, then a full read decodes from scratch
      xfer(cmd_byte(1'b1, 5'd31, 2'b00), 8'h00, 5, 1'b0, rd, bad);
      check("R7", sdo_oe, 1'b0, "enable after command abort");
      do_read(5'd9, 1'b0, 2'b00, "R7");
      // R7: abort inside read data
      xfer(cmd_byte(1'b1, 5'd0, 2'b00), 8'h00, 11, 1'b1, rd, bad);
      check("R7", sdo_oe, 1'b0, "enable after data abort");
      check("R7", rd[7:5], 3'b111, "leading bits before abort");
      do_read(5'd31, 1'b1, 2'b00, "R7");

      // R9: extra clocks after the data byte
      xfer(cmd_byte(1'b0, 5'd12, 2'b00), 8'h81, 21, 1'b0, rd, bad);
      check("R9", bad, 0, "enable with extra clocks");
      model[12] = 8'h81;
      do_read(5'd12, 1'b1, 2'b00, "R9");
      xfer(cmd_byte(1'b1, 5'd12, 2'b00), 8'h00, 20, 1'b0, rd, bad);
      check("R9", rd, 8'h81, "read with extra clocks");

      // random mix of reads and writes against the model (R2 R3 R4 R5 R6)
      for (int t = 0; t < 60; t++) begin
         logic [4:0] a;
         logic [7:0] d;
         logic s;
         logic [1:0] j;
         a = 5'($urandom_range(0, 31));
         d = 8'($urandom_range(0, 255));
         s = 1'($urandom_range(0, 1));
         j = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 1) == 0) do_write(a, d, s, j, "R3");
         else                           do_read(a, s, j, "R4");
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule